// File: doc/BRIEF.md
# Prescaled Timer/Counter Channel

This block is one timer/counter channel with a pair of byte-wide count registers (high and low). Each machine cycle is one rising edge of `clk`. In timer mode the count advances on ticks from a prescaler. The prescaler divides the machine-cycle rate by 1, 12 or 96. In counter mode the count advances on each falling edge detected on an external count pin. A run bit enables counting. An optional gate qualifies it with an external level.

Three count layouts are available:

- a 13-bit counter made of the whole high byte and the five low bits of the low byte;
- a full 16-bit counter;
- an 8-bit counter in the low byte that reloads from the high byte.

A sticky overflow flag is set whenever the active count wraps.

Software uses two write ports. A configuration write loads the run bit, the prescale select and the mode nibble in one word. A byte write port loads either count byte. A byte-select input also drives a read mux for the count bytes. The overflow flag is cleared by a one-cycle strobe.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset, both count bytes, the overflow flag and the whole configuration word (run, prescale, gate, counter select, mode) are zero.
- R2: The configuration word written on `cfg_wdata` uses these bit positions: bit 6 is run, bits 5:4 are the prescale select, bit 3 is gate, bit 2 is counter select (1 = count pin edges, 0 = prescaler ticks), and bits 1:0 are the mode. While run is 0 the count never changes except by a byte write.
- R3: In timer mode the count advances once every N machine cycles. The prescale select gives N: 00 gives 12, 01 gives 1, 10 gives 96, and 11 gives 12. The first advance comes N cycles after the run bit is written to 1.
- R4: The prescaler restarts from zero whenever run is 0, so time accumulated before a stop is lost.
- R5: In counter mode the count advances once per falling edge of `count_pin`. The advance happens on the second rising clock edge after the pin is seen low. A pin that toggles every machine cycle is counted on every one of its falling edges, which is half the machine-cycle rate.
- R6: With gate set, counting happens only while both `gate_pin` is 1 and run is 1. With gate clear, `gate_pin` has no effect.
- R7: In mode 00 the count is 13 bits: the high byte followed by low-byte bits 4:0. Low-byte bits 7:5 read as zero after any increment or low-byte write. The count wraps from 0x1FFF to 0.
- R8: In mode 01 the count is 16 bits with the high byte above the low byte. It wraps from 0xFFFF to 0.
- R9: In mode 10 the low byte counts. On the tick where it is 0xFF, it loads the high byte instead, and the high byte is unchanged.
- R10: In mode 11 the count bytes hold their value.
- R11: A wrap in any mode sets the overflow flag. The flag stays set until `ovf_clr` is pulsed. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R12: A byte write (`cnt_we`, `cnt_sel` 1 = high, 0 = low) in the same cycle as an advance wins. The written byte holds the written value, and that cycle's advance and wrap are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word {run, prescale[1:0], gate, ctr_sel, mode[1:0]} |
| cnt_we | input | 1 | Count byte write strobe |
| cnt_sel | input | 1 | Byte select for write and read (1 = high, 0 = low) |
| cnt_wdata | input | 8 | Count byte write data |
| cnt_rdata | output | 8 | Selected count byte |
| gate_pin | input | 1 | External gate level |
| count_pin | input | 1 | External count input |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A prescaler that is off by one shifts every timer-mode advance. That error shows in the count after a run of exactly N or N-1 cycles, so run lengths are chosen at those boundaries. A wrong edge-detector state either loses a count or adds a false count within two cycles of a pin change. A mode-decoding fault shows only at the wrap point, in the byte the wrap carries into and in the overflow flag, so counts are preloaded one or two steps below each wrap value. A dropped write-priority or clear-priority rule is visible in the very next cycle's read value or flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int LO13_W  = 5;
    localparam int CNT13_W = BYTE_W + LO13_W;
    localparam int CFG_W   = 7;

    typedef enum logic [1:0] {
        MD_13   = 2'b00,
        MD_16   = 2'b01,
        MD_RLD  = 2'b10,
        MD_HOLD = 2'b11
    } mode_e;

    typedef struct packed {
        logic       run;
        logic [1:0] psel;
        logic       gate;
        logic       ctr;
        mode_e      mode;
    } cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    typedef struct packed {
        cnt_t val;
        logic wrap;
    } step_t;

    // one advance of the count in the given layout
    function automatic step_t next_count(mode_e m, cnt_t c);
        step_t                s;
        logic [CNT13_W-1:0]   c13;
        logic [2*BYTE_W-1:0]  c16;
        s.val  = c;
        s.wrap = 1'b0;
        c13    = '0;
        c16    = '0;
        case (m)
            MD_13: begin
                c13      = {c.hi, c.lo[LO13_W-1:0]} + CNT13_W'(1);
                s.wrap   = &{c.hi, c.lo[LO13_W-1:0]};
                s.val.hi = c13[CNT13_W-1:LO13_W];
                s.val.lo = {{(BYTE_W-LO13_W){1'b0}}, c13[LO13_W-1:0]};
            end
            MD_16: begin
                c16    = c + (2*BYTE_W)'(1);
                s.wrap = &c;
                s.val  = c16;
            end
            MD_RLD: begin
                if (&c.lo) begin
                    s.val.lo = c.hi;
                    s.wrap   = 1'b1;
                end else begin
                    s.val.lo = c.lo + BYTE_W'(1);
                end
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_STD  = 12,
    parameter int DIV_SLOW = 96
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] psel,
    output logic       tick
);
    localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;

    always_comb begin
        case (psel)
            2'b01:   lim = '0;
            2'b10:   lim = PW'(DIV_SLOW - 1);
            default: lim = PW'(DIV_STD - 1);
        endcase
    end

    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic s_now;
    logic s_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_now <= 1'b0;
            s_old <= 1'b0;
        end else begin
            s_now <= pin;
            s_old <= s_now;
        end
    end

    assign fall = s_old && !s_now;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              inc,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovf_clr,
    output cnt_t              count,
    output logic              ovf
);
    step_t step;
    logic  adv;

    always_comb step = next_count(mode, count);

    assign adv = inc && !wr_en && (mode != MD_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_en) begin
            if (wr_hi)
                count.hi <= wr_data;
            else if (mode == MD_13)
                count.lo <= {{(BYTE_W-LO13_W){1'b0}}, wr_data[LO13_W-1:0]};
            else
                count.lo <= wr_data;
        end else if (adv) begin
            count <= step.val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (adv && step.wrap)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DIV_STD  = 12,
    parameter int DIV_SLOW = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cnt_we,
    input  logic              cnt_sel,
    input  logic [BYTE_W-1:0] cnt_wdata,
    output logic [BYTE_W-1:0] cnt_rdata,
    input  logic              gate_pin,
    input  logic              count_pin,
    input  logic              ovf_clr,
    output logic              ovf_flag
);
    cfg_t cfg;
    cnt_t count;
    logic tick;
    logic fall;
    logic enable;
    logic inc;

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_we)
            cfg <= cfg_t'(cfg_wdata);
    end

    assign enable = cfg.run && (!cfg.gate || gate_pin);
    assign inc    = enable && (cfg.ctr ? fall : tick);

    tmr_prescale #(
        .DIV_STD  (DIV_STD),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg.run),
        .psel (cfg.psel),
        .tick (tick)
    );

    tmr_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (count_pin),
        .fall (fall)
    );

    tmr_count u_cnt (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg.mode),
        .inc     (inc),
        .wr_en   (cnt_we),
        .wr_hi   (cnt_sel),
        .wr_data (cnt_wdata),
        .ovf_clr (ovf_clr),
        .count   (count),
        .ovf     (ovf_flag)
    );

    assign cnt_rdata = cnt_sel ? count.hi : count.lo;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input cfg_t              cfg_q,
    input cnt_t              cnt_q,
    input logic              cnt_we,
    input logic              cnt_sel,
    input logic [BYTE_W-1:0] cnt_wdata,
    input logic              gate_pin,
    input logic              ovf_clr,
    input logic              ovf_flag
);
    p_run_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !cnt_we) |=> $stable(cnt_q));

    p_gate_block_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.gate && !gate_pin && !cnt_we) |=> $stable(cnt_q));

    p_mask13_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && !cnt_sel && cfg_q.mode == MD_13) |=> (cnt_q.lo[7:5] == 3'b000));

    p_hold11_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_HOLD && !cnt_we) |=> $stable(cnt_q));

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_wr_hi_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && cnt_sel) |=> (cnt_q.hi == $past(cnt_wdata)));
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_q     (cfg),
    .cnt_q     (count),
    .cnt_we    (cnt_we),
    .cnt_sel   (cnt_sel),
    .cnt_wdata (cnt_wdata),
    .gate_pin  (gate_pin),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       cnt_we = 1'b0;
    logic       cnt_sel = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       gate_pin = 1'b0;
    logic       count_pin = 1'b1;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .gate_pin(gate_pin), .count_pin(count_pin),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [6:0] cfg;
        logic       gp;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [8:0] n;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic       eovf;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{7'h11, 1'b0, 8'h00, 8'h00, 9'd5,   8'h00, 8'h05, 1'b0, 4'd8},  // R8 plain count
        '{7'h11, 1'b0, 8'hFF, 8'hFE, 9'd3,   8'h00, 8'h01, 1'b1, 4'd8},  // R8 wrap
        '{7'h10, 1'b0, 8'hFF, 8'h1E, 9'd2,   8'h00, 8'h00, 1'b1, 4'd7},  // R7 wrap at 0x1FFF
        '{7'h10, 1'b0, 8'h00, 8'h1F, 9'd1,   8'h01, 8'h00, 1'b0, 4'd7},  // R7 carry into high
        '{7'h10, 1'b0, 8'h10, 8'hE3, 9'd1,   8'h10, 8'h04, 1'b0, 4'd7},  // R7 write masked
        '{7'h12, 1'b0, 8'hF0, 8'hFE, 9'd4,   8'hF0, 8'hF2, 1'b1, 4'd9},  // R9 reload
        '{7'h01, 1'b0, 8'h00, 8'h00, 9'd11,  8'h00, 8'h00, 1'b0, 4'd3},  // R3 div12 short
        '{7'h01, 1'b0, 8'h00, 8'h00, 9'd12,  8'h00, 8'h01, 1'b0, 4'd3},  // R3 div12 exact
        '{7'h01, 1'b0, 8'h00, 8'h00, 9'd30,  8'h00, 8'h02, 1'b0, 4'd3},  // R3 div12
        '{7'h21, 1'b0, 8'h00, 8'h00, 9'd200, 8'h00, 8'h02, 1'b0, 4'd3},  // R3 div96
        '{7'h31, 1'b0, 8'h00, 8'h00, 9'd25,  8'h00, 8'h02, 1'b0, 4'd3},  // R3 code 11
        '{7'h13, 1'b0, 8'h12, 8'h34, 9'd5,   8'h12, 8'h34, 1'b0, 4'd10}, // R10 hold
        '{7'h19, 1'b0, 8'h00, 8'h00, 9'd5,   8'h00, 8'h00, 1'b0, 4'd6},  // R6 gated off
        '{7'h19, 1'b1, 8'h00, 8'h00, 9'd5,   8'h00, 8'h05, 1'b0, 4'd6},  // R6 gated on
        '{7'h11, 1'b0, 8'h00, 8'h00, 9'd5,   8'h00, 8'h05, 1'b0, 4'd6},  // R6 gate unused
        '{7'h15, 1'b0, 8'h00, 8'h00, 9'd10,  8'h00, 8'h00, 1'b0, 4'd5}   // R5 pin idle
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [6:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic sel, input logic [7:0] d);
        cnt_we = 1'b1; cnt_sel = sel; cnt_wdata = d;
        cyc();
        cnt_we = 1'b0;
    endtask

    task automatic clr_ovf();
        ovf_clr = 1'b1;
        cyc();
        ovf_clr = 1'b0;
    endtask

    task automatic run_for(input logic [6:0] c, input int n);
        wr_cfg(c | 7'h40);
        repeat (n - 1) cyc();
        wr_cfg(c & 7'h3F);
    endtask

    task automatic rd16(output logic [15:0] v);
        cnt_sel = 1'b1; #1; v[15:8] = cnt_rdata;
        cnt_sel = 1'b0; #1; v[7:0] = cnt_rdata;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        rd16(v);
        chk("R1 count", v, 16'h0000);
        chk("R1 ovf", {15'd0, ovf_flag}, 16'd0);
        // R2 run bit zero after reset: nothing counts
        repeat (20) cyc();
        rd16(v);
        chk("R2 idle count", v, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            clr_ovf();
            wr_cfg(VECS[i].cfg);
            wr_cnt(1'b0, VECS[i].lo);
            wr_cnt(1'b1, VECS[i].hi);
            gate_pin = VECS[i].gp;
            run_for(VECS[i].cfg, int'(VECS[i].n));
            rd16(v);
            chk($sformatf("R%0d vec%0d count", VECS[i].req, i), v, {VECS[i].ehi, VECS[i].elo});
            chk($sformatf("R%0d vec%0d ovf", VECS[i].req, i), {15'd0, ovf_flag}, {15'd0, VECS[i].eovf});
        end
        gate_pin = 1'b0;

        // R5 two-cycle recognition and full-rate toggling
        wr_cfg(7'h15);
        wr_cnt(1'b0, 8'h00);
        wr_cnt(1'b1, 8'h00);
        count_pin = 1'b1;
        wr_cfg(7'h55);
        cyc(); cyc();
        count_pin = 1'b0;
        cyc();
        rd16(v);
        chk("R5 one edge after fall", v, 16'h0000);
        cyc();
        rd16(v);
        chk("R5 two edges after fall", v, 16'h0001);
        for (int k = 0; k < 4; k++) begin
            count_pin = 1'b1; cyc();
            count_pin = 1'b0; cyc();
        end
        cyc(); cyc();
        rd16(v);
        chk("R5 toggle every cycle", v, 16'h0005);
        wr_cfg(7'h15);
        count_pin = 1'b1;

        // R12 write beats increment
        wr_cfg(7'h11);
        wr_cnt(1'b0, 8'h00);
        wr_cnt(1'b1, 8'h00);
        wr_cfg(7'h51);
        repeat (3) cyc();
        rd16(v);
        chk("R12 pre-write count", v, 16'h0003);
        wr_cnt(1'b0, 8'h50);
        rd16(v);
        chk("R12 write wins", v, 16'h0050);
        cyc();
        rd16(v);
        chk("R12 resumes", v, 16'h0051);
        wr_cfg(7'h11);

        // R11 set wins over clear, then clear alone
        clr_ovf();
        wr_cfg(7'h12);
        wr_cnt(1'b0, 8'hFF);
        wr_cnt(1'b1, 8'h00);
        wr_cfg(7'h52);
        ovf_clr = 1'b1;
        cyc();
        ovf_clr = 1'b0;
        chk("R11 set beats clear", {15'd0, ovf_flag}, 16'd1);
        rd16(v);
        chk("R9 reload from high", v, 16'h0000);
        wr_cfg(7'h12);
        clr_ovf();
        chk("R11 clear", {15'd0, ovf_flag}, 16'd0);

        // R4 prescaler restarts after a stop
        wr_cfg(7'h01);
        wr_cnt(1'b0, 8'h00);
        wr_cnt(1'b1, 8'h00);
        run_for(7'h01, 6);
        run_for(7'h01, 11);
        rd16(v);
        chk("R4 partial time lost", v, 16'h0000);
        run_for(7'h01, 12);
        rd16(v);
        chk("R4 full period", v, 16'h0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule